// File: doc/BRIEF.md
# Four-Level Address Translation Walker (4 KB Granule)

This block turns a 64-bit virtual address into a 48-bit physical address by reading 64-bit descriptors from translation tables in memory, one level at a time. Pages are 4 KB, every table holds 512 eight-byte entries, and each level consumes nine bits of the virtual address. The caller gives a virtual address, two table base values (one for the bottom of the address space and one for the top), a size field `sz` that sets the usable space to 2^(64 − sz) bytes, and a read/write flag. The walker returns either a physical address with the attribute bits of the final descriptor, or a fault code that names the level where the walk stopped.

The walk does not always start at level 0. A size of 25 to 33 gives a 39- to 31-bit space and the base table is read as a level-1 table. A size of 34 to 39 gives 1 GB or less and the base table is read as a level-2 table. Level-1 entries may map 1 GB blocks, level-2 entries 2 MB blocks, and level-3 entries 4 KB pages. Out-of-range addresses and sizes are rejected before any memory is read. There is no permission check, no access-flag handling, and no caching of results.

Top module: `pt_walker`

## Requirements
- R1: When va[63:48] is all zeros the walk uses `base_lo`; when it is all ones the walk uses `base_hi`; any other value gives a translation fault at level 0 (status 0x04) with no memory read.
- R2: A size `sz` below 25 or above 39 gives a configuration fault (status 0x21) with no memory read. This check takes priority over R1 and R3.
- R3: Every address bit at position 64 − sz or above must equal the selected half: 0 for the low half, 1 for the high half. If any bit differs, the result is a level-0 translation fault (status 0x04) with no memory read.
- R4: For sz 25..33 the first read is at level 1 with index va[38:30]. For sz 34..39 the first read is at level 2 with index va[29:21]. In both cases, index bits that sit at address positions 64 − sz or above are forced to zero.
- R5: A descriptor is read from address {table[47:12], index[8:0], 3'b000}. The table is bits [47:12] of the base value at the start level, and bits [47:12] of the previous table descriptor at each later level. Level l uses index va[47−9l : 39−9l].
- R6: Descriptor bits [1:0] are decoded as follows. Bit 0 = 0 means invalid. 2'b11 below level 3 means a table. 2'b11 at level 3 means a page. 2'b01 at level 1 or 2 means a block. 2'b01 at level 3 means invalid.
- R7: The physical address is {d[47:30], va[29:0]} for a level-1 block, {d[47:21], va[20:0]} for a level-2 block, and {d[47:12], va[11:0]} for a level-3 page.
- R8: An invalid descriptor at level L gives status {4'b0001, L[1:0]}. For example, level 2 gives 0x06. `fault_write` equals the request's `is_write` on every fault and is 0 on success.
- R9: On success, `attr` = {d[63:52], d[11:2]} of the final descriptor, and `fault` = 0.
- R10: `done` is high for exactly one cycle per accepted `start`. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held steady. `start` is only accepted while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when not busy) |
| va | input | 64 | Virtual address |
| base_lo | input | 64 | Table base for the low half (bits 47:12 used) |
| base_hi | input | 64 | Table base for the high half (bits 47:12 used) |
| sz | input | 6 | Address-space size field |
| is_write | input | 1 | Access is a write |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| pa | output | 48 | Physical address |
| attr | output | 22 | Attribute bits of the final descriptor |
| fault | output | 1 | Walk ended in a fault |
| fault_status | output | 6 | Fault code |
| fault_write | output | 1 | Faulting access was a write |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor data |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, and never sends a response when no read is outstanding. They also assume that `start` is raised only while `busy` is low. The bench memory model answers one cycle after each accepted read, and it stalls `mem_req_ready` in a repeating pattern so that the hold rule is exercised. The driver raises `start` only after the previous result has been taken. Addresses and sizes are chosen to reach every start level, every leaf size, both halves, index masking, and each fault kind, so every path the assertions guard is visited.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int VA_W    = 64;
    localparam int PA_W    = 48;
    localparam int IDX_W   = 9;
    localparam int PG_SH   = 12;
    localparam int DESC_W  = 64;
    localparam int TBL_W   = PA_W - PG_SH;
    localparam int ATTR_W  = 22;
    localparam int SZ_W    = 6;
    localparam int LVL_W   = 2;
    localparam logic [5:0] CFG_FAULT = 6'h21;

    typedef enum logic [1:0] {
        WS_IDLE, WS_REQ, WS_WAIT, WS_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        DK_INVALID, DK_TABLE, DK_LEAF
    } desc_kind_t;

    typedef struct packed {
        desc_kind_t              kind;
        logic [TBL_W-1:0]        next_tbl;
        logic [PA_W-1:0]         leaf_pa;
        logic [ATTR_W-1:0]       attr;
    } desc_info_t;

    function automatic logic [5:0] xlat_fault(input logic [LVL_W-1:0] lvl);
        return {4'b0001, lvl};
    endfunction

    function automatic int lvl_shift(input logic [LVL_W-1:0] lvl);
        return 39 - IDX_W * int'(lvl);
    endfunction
endpackage

// File: rtl/pt_range_check.sv
module pt_range_check
    import pt_walker_pkg::*;
#(
    parameter int SZ_LO     = 25,
    parameter int SZ_HI     = 39,
    parameter int SZ_L2_MIN = 34
) (
    input  logic [VA_W-1:0]   va,
    input  logic [SZ_W-1:0]   sz,
    output logic              cfg_bad,
    output logic              range_bad,
    output logic              use_high,
    output logic [LVL_W-1:0]  start_lvl,
    output logic [VA_W-1:0]   hi_mask
);
    localparam int TOP_LSB = 48;

    logic [6:0] va_bits;
    logic       top_zero, top_ones;

    assign va_bits = 7'd64 - {1'b0, sz};

    for (genvar i = 0; i < VA_W; i++) begin : g_mask
        assign hi_mask[i] = (7'(i) >= va_bits);
    end

    assign top_zero  = ~|va[VA_W-1:TOP_LSB];
    assign top_ones  = &va[VA_W-1:TOP_LSB];
    assign use_high  = top_ones;
    assign cfg_bad   = (int'(sz) < SZ_LO) || (int'(sz) > SZ_HI);
    assign range_bad = !(top_zero || top_ones) ||
                       (|((va ^ {VA_W{top_ones}}) & hi_mask));
    assign start_lvl = (int'(sz) >= SZ_L2_MIN) ? LVL_W'(2) : LVL_W'(1);
endmodule

// File: rtl/pt_index_gen.sv
module pt_index_gen
    import pt_walker_pkg::*;
(
    input  logic [VA_W-1:0]   va,
    input  logic [VA_W-1:0]   hi_mask,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [TBL_W-1:0]  tbl,
    output logic [PA_W-1:0]   desc_addr
);
    logic [VA_W-1:0]  va_in_range;
    logic [IDX_W-1:0] idx;

    assign va_in_range = va & ~hi_mask;

    always_comb begin
        idx = IDX_W'(va_in_range >> lvl_shift(lvl));
    end

    assign desc_addr = {tbl, idx, 3'b000};
endmodule

// File: rtl/pt_desc_decode.sv
module pt_desc_decode
    import pt_walker_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [VA_W-1:0]   va,
    output desc_info_t        info
);
    always_comb begin
        info.next_tbl = desc[PA_W-1:PG_SH];
        info.attr     = {desc[63:52], desc[11:2]};
        info.leaf_pa  = '0;
        info.kind     = DK_INVALID;
        if (desc[0]) begin
            if (desc[1]) begin
                info.kind = (lvl == 2'd3) ? DK_LEAF : DK_TABLE;
            end else if (lvl == 2'd1 || lvl == 2'd2) begin
                info.kind = DK_LEAF;
            end
        end
        unique case (lvl)
            2'd1:    info.leaf_pa = {desc[PA_W-1:30], va[29:0]};
            2'd2:    info.leaf_pa = {desc[PA_W-1:21], va[20:0]};
            2'd3:    info.leaf_pa = {desc[PA_W-1:12], va[11:0]};
            default: info.leaf_pa = '0;
        endcase
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int SZ_LO     = 25,
    parameter int SZ_HI     = 39,
    parameter int SZ_L2_MIN = 34
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [VA_W-1:0]     va,
    input  logic [63:0]         base_lo,
    input  logic [63:0]         base_hi,
    input  logic [SZ_W-1:0]     sz,
    input  logic                is_write,
    output logic                busy,
    output logic                done,
    output logic [PA_W-1:0]     pa,
    output logic [ATTR_W-1:0]   attr,
    output logic                fault,
    output logic [5:0]          fault_status,
    output logic                fault_write,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DESC_W-1:0]   mem_rsp_data
);
    walk_state_t       state;
    logic [VA_W-1:0]   va_q, mask_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [TBL_W-1:0]  tbl_q;
    logic              wr_q;

    logic              cfg_bad, range_bad, use_high;
    logic [LVL_W-1:0]  start_lvl;
    logic [VA_W-1:0]   rc_mask;
    desc_info_t        dinfo;

    pt_range_check #(
        .SZ_LO(SZ_LO), .SZ_HI(SZ_HI), .SZ_L2_MIN(SZ_L2_MIN)
    ) u_range (
        .va(va), .sz(sz), .cfg_bad(cfg_bad), .range_bad(range_bad),
        .use_high(use_high), .start_lvl(start_lvl), .hi_mask(rc_mask)
    );

    pt_index_gen u_index (
        .va(va_q), .hi_mask(mask_q), .lvl(lvl_q), .tbl(tbl_q),
        .desc_addr(mem_req_addr)
    );

    pt_desc_decode u_decode (
        .desc(mem_rsp_data), .lvl(lvl_q), .va(va_q), .info(dinfo)
    );

    assign busy          = (state != WS_IDLE);
    assign done          = (state == WS_DONE);
    assign mem_req_valid = (state == WS_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= WS_IDLE;
            va_q         <= '0;
            mask_q       <= '0;
            lvl_q        <= '0;
            tbl_q        <= '0;
            wr_q         <= 1'b0;
            pa           <= '0;
            attr         <= '0;
            fault        <= 1'b0;
            fault_status <= '0;
            fault_write  <= 1'b0;
        end else begin
            unique case (state)
                WS_IDLE: begin
                    if (start) begin
                        va_q         <= va;
                        mask_q       <= rc_mask;
                        wr_q         <= is_write;
                        pa           <= '0;
                        attr         <= '0;
                        fault        <= 1'b0;
                        fault_status <= '0;
                        fault_write  <= 1'b0;
                        if (cfg_bad) begin
                            fault        <= 1'b1;
                            fault_status <= CFG_FAULT;
                            fault_write  <= is_write;
                            state        <= WS_DONE;
                        end else if (range_bad) begin
                            fault        <= 1'b1;
                            fault_status <= xlat_fault(2'd0);
                            fault_write  <= is_write;
                            state        <= WS_DONE;
                        end else begin
                            tbl_q <= use_high ? base_hi[PA_W-1:PG_SH]
                                              : base_lo[PA_W-1:PG_SH];
                            lvl_q <= start_lvl;
                            state <= WS_REQ;
                        end
                    end
                end
                WS_REQ: begin
                    if (mem_req_ready) state <= WS_WAIT;
                end
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        unique case (dinfo.kind)
                            DK_TABLE: begin
                                tbl_q <= dinfo.next_tbl;
                                lvl_q <= lvl_q + 2'd1;
                                state <= WS_REQ;
                            end
                            DK_LEAF: begin
                                pa    <= dinfo.leaf_pa;
                                attr  <= dinfo.attr;
                                state <= WS_DONE;
                            end
                            default: begin
                                fault        <= 1'b1;
                                fault_status <= xlat_fault(lvl_q);
                                fault_write  <= wr_q;
                                state        <= WS_DONE;
                            end
                        endcase
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // R10: a stalled request keeps its address
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: result strobe lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: level 0 is never read
    a_r4_no_level0_read: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (lvl_q != 2'd0));

    // R2: bad size ends the walk without a read
    a_r2_cfg_no_read: assert property (@(posedge clk) disable iff (rst)
        (state == WS_IDLE && start && cfg_bad) |=>
            (done && !mem_req_valid && fault_status == CFG_FAULT));

    // R3: out-of-range address ends the walk without a read
    a_r3_range_no_read: assert property (@(posedge clk) disable iff (rst)
        (state == WS_IDLE && start && !cfg_bad && range_bad) |=>
            (done && !mem_req_valid && fault_status == 6'h04));

    // R8: translation fault codes carry the 0b0001 prefix
    a_r8_fault_code: assert property (@(posedge clk) disable iff (rst)
        (done && fault && fault_status != CFG_FAULT) |-> (fault_status[5:2] == 4'b0001));

    // R7: successful translation keeps the page offset
    a_r7_page_offset: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (pa[11:0] == va_q[11:0] && !fault_write));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] va, base_lo, base_hi;
    logic [5:0]  sz;
    logic        is_write;
    logic        busy, done, fault, fault_write;
    logic [47:0] pa;
    logic [21:0] attr;
    logic [5:0]  fault_status;
    logic        mem_req_valid, mem_req_ready;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    always #2 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst(rst), .start(start), .va(va), .base_lo(base_lo),
        .base_hi(base_hi), .sz(sz), .is_write(is_write), .busy(busy),
        .done(done), .pa(pa), .attr(attr), .fault(fault),
        .fault_status(fault_status), .fault_write(fault_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic        flt;
        logic [5:0]  st;
        logic        wr;
        logic [47:0] pa;
        logic [21:0] attr;
        int          reads;
        int          base;
        string       tag;
    } exp_t;

    logic [63:0] mem [logic [47:0]];
    exp_t        sbq[$];
    int          total = 0, bad = 0, reads_total = 0;
    logic [1:0]  rcnt = 2'd0;

    function automatic logic [63:0] rd(input logic [47:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // memory model: stalls one cycle in four, answers one cycle after accept
    assign mem_req_ready = (rcnt != 2'd0);
    always @(posedge clk) begin
        rcnt          <= rcnt + 2'd1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rd(mem_req_addr);
            reads_total   <= reads_total + 1;
        end
    end

    // expected result straight from the requirement text
    function automatic exp_t model(input logic [63:0] v, input logic [5:0] s,
                                   input logic w, input string tag);
        exp_t e;
        logic hi;
        int   vb, lvl, sh;
        logic [47:0] tbl;
        logic [8:0]  idx;
        logic [63:0] d;
        e = '{flt:1'b0, st:6'h0, wr:1'b0, pa:48'h0, attr:22'h0, reads:0,
              base:0, tag:tag};
        if (s < 25 || s > 39) begin            // R2
            e.flt = 1; e.st = 6'h21; e.wr = w; return e;
        end
        if (v[63:48] == 16'h0) hi = 0;         // R1
        else if (v[63:48] == 16'hFFFF) hi = 1;
        else begin e.flt = 1; e.st = 6'h04; e.wr = w; return e; end
        vb = 64 - int'(s);
        for (int i = vb; i < 64; i++)          // R3
            if (v[i] != hi) begin e.flt = 1; e.st = 6'h04; e.wr = w; return e; end
        lvl = (s >= 34) ? 2 : 1;               // R4
        tbl = hi ? {base_hi[47:12], 12'h0} : {base_lo[47:12], 12'h0};
        while (1) begin
            sh = 39 - 9 * lvl;
            for (int b = 0; b < 9; b++)
                idx[b] = (sh + b < vb) ? v[sh + b] : 1'b0;
            d = rd({tbl[47:12], idx, 3'b000}); // R5
            e.reads++;
            if (d[0] && d[1] && lvl < 3) begin // R6 table
                tbl = {d[47:12], 12'h0};
                lvl++;
            end else if ((d[1:0] == 2'b11 && lvl == 3) ||
                         (d[1:0] == 2'b01 && lvl < 3)) begin
                case (lvl)                     // R7
                    1: e.pa = {d[47:30], v[29:0]};
                    2: e.pa = {d[47:21], v[20:0]};
                    default: e.pa = {d[47:12], v[11:0]};
                endcase
                e.attr = {d[63:52], d[11:2]};  // R9
                return e;
            end else begin                     // R8
                e.flt = 1; e.st = {4'b0001, 2'(lvl)}; e.wr = w; return e;
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string what, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pop and compare on every result strobe
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            if (sbq.size() == 0) begin
                check(1'b0, "unexpected done", "R10", 64'd1, 64'd0);
            end else begin
                e = sbq.pop_front();
                check(fault == e.flt && fault_status == e.st && fault_write == e.wr,
                      "fault/status/write", e.tag,
                      {56'd0, fault, fault_write, fault_status},
                      {56'd0, e.flt, e.wr, e.st});
                if (!e.flt)
                    check(pa == e.pa && attr == e.attr, "pa/attr", e.tag,
                          {pa, 16'd0}, {e.pa, 16'd0});
                check((reads_total - e.base) == e.reads, "read count", e.tag,
                      64'(reads_total - e.base), 64'(e.reads));
            end
        end
    end

    task automatic run(input logic [63:0] v, input logic [5:0] s,
                       input logic w, input string tag);
        exp_t e;
        e = model(v, s, w, tag);
        e.base = reads_total;
        sbq.push_back(e);
        @(negedge clk);
        va = v; sz = s; is_write = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (sbq.size() == 0);
        @(negedge clk);
        check(!done && !busy, "strobe single cycle", "R10",
              {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; va = '0; sz = 6'd25; is_write = 1'b0;
        base_lo = 64'h0000_0000_0001_0000;
        base_hi = 64'h0000_0000_0002_0000;
        // low-half level-1 table
        mem[48'h10000] = 64'h0060_0000_C000_0705;   // 1 GB block
        mem[48'h10008] = 64'h0000_0000_0003_0003;   // -> L2 0x30000
        mem[48'h10018] = 64'h0000_0000_0003_1003;   // -> L2 0x31000 (empty)
        mem[48'h10048] = 64'h00A0_0000_0AE0_0C01;   // idx 9, L2 block when read as L2
        // high-half level-1 table
        mem[48'h20008] = 64'h0000_0000_0003_0003;
        // level-2 table
        mem[48'h30000] = 64'h0010_0000_1240_0F45;   // 2 MB block
        mem[48'h30008] = 64'h0000_0000_0005_0003;   // -> L3 0x50000
        // level-3 table
        mem[48'h50000] = 64'h00E0_0000_7777_7F43;   // page
        mem[48'h50008] = 64'h0000_0000_8888_8001;   // 01 at L3 -> invalid
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_req_valid && !fault, "reset state", "R10",
              {60'd0, busy, done, mem_req_valid, fault}, 64'd0);

        run(64'h0000_0000_1234_5678, 6'd25, 1'b0, "R7 L1 block");
        run(64'h0000_0000_4001_2345, 6'd25, 1'b0, "R7 L2 block via table R6");
        run(64'h0000_0000_4020_0ABC, 6'd25, 1'b1, "R7 L3 page R5");
        run(64'h0000_0000_4020_1ABC, 6'd25, 1'b1, "R6 L3 01 invalid");
        run(64'h0000_0000_4040_0000, 6'd25, 1'b1, "R8 L2 invalid write");
        run(64'h0000_0000_8000_0000, 6'd25, 1'b0, "R8 L1 invalid read");
        run(64'h0000_0000_0123_4567, 6'd36, 1'b0, "R4 start L2");
        run(64'h0000_0000_0120_0000, 6'd39, 1'b0, "R4 sz39 index mask");
        run(64'hFFFF_FF80_4020_0123, 6'd25, 1'b0, "R1 high half page R9");
        run(64'hFFFF_FFFF_C000_1234, 6'd33, 1'b0, "R4 high half index mask");
        run(64'h0001_0000_0000_0000, 6'd25, 1'b1, "R1 mixed top bits");
        run(64'h0000_0100_0000_0000, 6'd30, 1'b0, "R3 above size");
        run(64'hFFFF_FF00_0000_0000, 6'd25, 1'b0, "R3 high half hole");
        run(64'h0000_0000_1234_5678, 6'd20, 1'b1, "R2 size low");
        run(64'h0001_0000_0000_0000, 6'd40, 1'b0, "R2 size high priority");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule